// File: doc/BRIEF.md
# Keyboard/Display Port Interface

This block is a small bus slave that connects a processor bus to a character keyboard and a character display. It occupies four byte addresses above a fixed base address. It holds the last key code received, the last character sent to the display, a status byte and a control byte. Software polls or takes an interrupt, then moves one character per access.

The keyboard side presents a character with a one-cycle strobe. The display side receives each written character with a one-cycle load strobe and reports completion with a one-cycle done strobe. Status flags are set by these device events and cleared as a side effect of software touching the data registers. Two enable bits in the control byte gate the two request sources onto one shared interrupt output.

Every bus access uses a two-wire handshake. The master raises master-ready with the address, direction and write data held stable. The slave performs the access once and answers with a one-cycle slave-ready pulse, with read data valid in that same cycle.

Top module: `kbd_disp_port`

## Requirements
- R1: An access takes place only when bus_addr[31:2] equals BASE_ADDR[31:2]. For any other address, bus_srdy stays low and no register changes.
- R2: When bus_mrdy is sampled high with a matching address and bus_srdy is low, exactly one access is performed. bus_srdy is high for exactly the next cycle. No second access starts while bus_srdy is high.
- R3: A key_valid strobe loads key_char into the key register and sets the key-waiting flag (STATUS bit 0). A strobe that arrives while the flag is already set overwrites the code and leaves the flag set.
- R4: A read at offset 0 returns the key register and clears the key-waiting flag. If a key_valid strobe arrives in the same cycle as that read, the read returns the old code and the flag stays set.
- R5: The display-ready flag (STATUS bit 1) is 1 after reset. A write at offset 1 stores the character on disp_char, pulses disp_load for one cycle and clears the flag. A disp_done strobe sets the flag again. If the write and the strobe fall in the same cycle, the write wins.
- R6: CONTROL at offset 3 holds the keyboard interrupt enable in bit 2 and the display interrupt enable in bit 1. Its other bits read as 0.
- R7: STATUS at offset 2 reads {display request, keyboard request, 4'b0, display-ready, key-waiting}. The keyboard request is key-waiting AND bit 2 of CONTROL. The display request is display-ready AND bit 1 of CONTROL. irq is the OR of the two requests.
- R8: Writes at offsets 0 and 2 change nothing but still complete the handshake. A read at offset 1 returns the last character written.
- R9: After a synchronous reset, CONTROL reads 0x00, STATUS reads 0x02, irq and disp_load are 0 and bus_srdy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address from the master |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 8 | Write data |
| bus_mrdy | input | 1 | Master-ready request |
| bus_rdata | output | 8 | Read data, valid while bus_srdy is high |
| bus_srdy | output | 1 | Slave-ready answer, one cycle per access |
| key_valid | input | 1 | One-cycle strobe: a new key code is present |
| key_char | input | 8 | Key code |
| disp_done | input | 1 | One-cycle strobe: display can take another character |
| disp_char | output | 8 | Character for the display |
| disp_load | output | 1 | One-cycle strobe: disp_char is new |
| irq | output | 1 | Shared interrupt request |

## Verification
A wrong flag shows up at the next STATUS read and on irq in the same cycle, because irq is built straight from the flags. A lost or extra load strobe, or a wrong clear of display-ready, appears on disp_load one cycle after the write. A double access or a missing answer shows as a second or absent bus_srdy pulse one cycle after master-ready is sampled. The bench compares every output on every cycle against a behavioural model, so a divergence is reported at the first cycle it becomes visible. The same-cycle collisions between a device strobe and a software access are driven on purpose, because an ordering error there stays hidden under ordinary traffic.

// File: rtl/kdp_pkg.sv
// kdp_pkg: shared constants and helpers for the keyboard/display port.
// Assumes byte-wide registers on a 4-byte aligned window.
package kdp_pkg;

    localparam int DATA_W = 8;
    localparam int OFFS_W = 2;

    // Register select, value equals the address offset
    typedef enum logic [OFFS_W-1:0] {
        SEL_KEY  = 2'd0,
        SEL_DISP = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Status bit positions
    localparam int ST_KWAIT = 0;
    localparam int ST_DRDY  = 1;
    localparam int ST_KREQ  = 6;
    localparam int ST_DREQ  = 7;

    // Control bit positions
    localparam int CT_DEN = 1;
    localparam int CT_KEN = 2;

    // Assemble the status byte from the flags and enables
    function automatic logic [DATA_W-1:0] status_byte(
        input logic kwait, input logic drdy,
        input logic ken,   input logic den);
        logic [DATA_W-1:0] s;
        s = '0;
        s[ST_KWAIT] = kwait;
        s[ST_DRDY]  = drdy;
        s[ST_KREQ]  = kwait & ken;
        s[ST_DREQ]  = drdy & den;
        return s;
    endfunction

    // Assemble the control byte; unused bits are zero
    function automatic logic [DATA_W-1:0] control_byte(
        input logic ken, input logic den);
        logic [DATA_W-1:0] c;
        c = '0;
        c[CT_KEN] = ken;
        c[CT_DEN] = den;
        return c;
    endfunction

endpackage

// File: rtl/kdp_decode.sv
// kdp_decode: compares the upper address bits with the base address and
// returns a register select from the low bits.
// Assumes BASE_ADDR is aligned to the 4-byte register window.
module kdp_decode
    import kdp_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_sel_e          sel
);

    // Window match and register select
    always_comb begin
        hit = (addr[ADDR_W-1:OFFS_W] == BASE_ADDR[ADDR_W-1:OFFS_W]);
        sel = reg_sel_e'(addr[OFFS_W-1:0]);
    end

endmodule

// File: rtl/kdp_handshake.sv
// kdp_handshake: turns a master-ready request into exactly one access and a
// one-cycle slave-ready answer. It also captures read data for that answer.
// Assumes the master holds address, direction and data until slave-ready.
module kdp_handshake
    import kdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrdy,
    input  logic              rnw,
    input  logic              hit,
    input  logic [DATA_W-1:0] rd_mux,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic              srdy,
    output logic [DATA_W-1:0] rdata
);

    logic acc;

    // An access fires once per request; a pending answer blocks a repeat
    always_comb begin
        acc    = mrdy & hit & ~srdy;
        acc_rd = acc & rnw;
        acc_wr = acc & ~rnw;
    end

    // Answer pulse and captured read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srdy  <= 1'b0;
            rdata <= '0;
        end else begin
            srdy <= acc;
            if (acc_rd) begin
                rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/kdp_kbd.sv
// kdp_kbd: keyboard side. Holds the last key code and the key-waiting flag.
// A device strobe has priority over a software read in the same cycle.
module kdp_kbd
    import kdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_char,
    input  logic              rd_key,
    output logic [DATA_W-1:0] key_q,
    output logic              kwait
);

    // Key code register: each strobe overwrites it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (key_valid) begin
            key_q <= key_char;
        end
    end

    // Key-waiting flag: set by a strobe, cleared by a read, strobe wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kwait <= 1'b0;
        end else if (key_valid) begin
            kwait <= 1'b1;
        end else if (rd_key) begin
            kwait <= 1'b0;
        end
    end

endmodule

// File: rtl/kdp_disp.sv
// kdp_disp: display side. Holds the outgoing character, emits the load
// strobe and keeps the display-ready flag. A software write has priority
// over a done strobe in the same cycle.
module kdp_disp
    import kdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_disp,
    input  logic [DATA_W-1:0] wdata,
    input  logic              disp_done,
    output logic [DATA_W-1:0] disp_q,
    output logic              disp_load,
    output logic              drdy
);

    // Outgoing character and its load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q    <= '0;
            disp_load <= 1'b0;
        end else begin
            disp_load <= wr_disp;
            if (wr_disp) begin
                disp_q <= wdata;
            end
        end
    end

    // Display-ready flag: idle display is ready out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy <= 1'b1;
        end else if (wr_disp) begin
            drdy <= 1'b0;
        end else if (disp_done) begin
            drdy <= 1'b1;
        end
    end

endmodule

// File: rtl/kdp_ctrl.sv
// kdp_ctrl: the two interrupt enables written through the control byte.
module kdp_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic ken_d,
    input  logic den_d,
    output logic ken,
    output logic den
);

    // Enable bits, both cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ken <= 1'b0;
            den <= 1'b0;
        end else if (wr_ctrl) begin
            ken <= ken_d;
            den <= den_d;
        end
    end

endmodule

// File: rtl/kbd_disp_port.sv
// kbd_disp_port: memory-mapped keyboard/display port with four byte
// registers (key code, display character, status, control). It uses a
// master-ready/slave-ready handshake and one shared interrupt output.
// Assumes single-beat byte accesses and one-cycle device strobes.
module kbd_disp_port
    import kdp_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rnw,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_mrdy,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_srdy,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_char,
    input  logic              disp_done,
    output logic [DATA_W-1:0] disp_char,
    output logic              disp_load,
    output logic              irq
);

    logic              hit;
    reg_sel_e          sel;
    logic              acc_rd;
    logic              acc_wr;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] key_q;
    logic              kwait;
    logic              drdy;
    logic              ken;
    logic              den;
    logic              rd_key;
    logic              wr_disp;
    logic              wr_ctrl;

    kdp_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .hit  (hit),
        .sel  (sel)
    );

    kdp_handshake u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .mrdy   (bus_mrdy),
        .rnw    (bus_rnw),
        .hit    (hit),
        .rd_mux (rd_mux),
        .acc_rd (acc_rd),
        .acc_wr (acc_wr),
        .srdy   (bus_srdy),
        .rdata  (bus_rdata)
    );

    // Per-register strobes; writes at the key and status offsets go nowhere
    always_comb begin
        rd_key  = acc_rd & (sel == SEL_KEY);
        wr_disp = acc_wr & (sel == SEL_DISP);
        wr_ctrl = acc_wr & (sel == SEL_CTRL);
    end

    kdp_kbd u_kbd (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_char  (key_char),
        .rd_key    (rd_key),
        .key_q     (key_q),
        .kwait     (kwait)
    );

    kdp_disp u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_disp   (wr_disp),
        .wdata     (bus_wdata),
        .disp_done (disp_done),
        .disp_q    (disp_char),
        .disp_load (disp_load),
        .drdy      (drdy)
    );

    kdp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .ken_d   (bus_wdata[CT_KEN]),
        .den_d   (bus_wdata[CT_DEN]),
        .ken     (ken),
        .den     (den)
    );

    // Read data selection by register offset
    always_comb begin
        unique case (sel)
            SEL_KEY:  rd_mux = key_q;
            SEL_DISP: rd_mux = disp_char;
            SEL_STAT: rd_mux = status_byte(kwait, drdy, ken, den);
            SEL_CTRL: rd_mux = control_byte(ken, den);
            default:  rd_mux = '0;
        endcase
    end

    // Shared request: either gated source raises it
    always_comb begin
        irq = (kwait & ken) | (drdy & den);
    end

endmodule

// File: rtl/kdp_chk.sv
// kdp_chk: protocol and flag properties for kbd_disp_port, attached by bind.
module kdp_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_mrdy,
    input logic bus_srdy,
    input logic key_valid,
    input logic disp_load,
    input logic irq,
    input logic kwait,
    input logic drdy,
    input logic ken,
    input logic den
);

    // R2
    srdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_srdy |=> !bus_srdy);

    // R2
    srdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_srdy |-> $past(bus_mrdy));

    // R3
    key_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> kwait);

    // R5
    load_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_load |-> !drdy);

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((kwait && ken) || (drdy && den)));

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((kwait && ken) || (drdy && den)) |-> irq);

endmodule

bind kbd_disp_port kdp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_mrdy  (bus_mrdy),
    .bus_srdy  (bus_srdy),
    .key_valid (key_valid),
    .disp_load (disp_load),
    .irq       (irq),
    .kwait     (kwait),
    .drdy      (drdy),
    .ken       (ken),
    .den       (den)
);

// File: tb/kbd_disp_port_tb.sv
`timescale 1ns/1ps
module kbd_disp_port_tb;

    localparam logic [31:0] BASE = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rnw = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_mrdy = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_srdy;
    logic        key_valid = 1'b0;
    logic [7:0]  key_char = '0;
    logic        disp_done = 1'b0;
    logic [7:0]  disp_char;
    logic        disp_load;
    logic        irq;

    int vectors = 0;
    int misses  = 0;
    bit summary_done = 0;

    always #2 clk = ~clk;

    kbd_disp_port #(.ADDR_W(32), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_wdata(bus_wdata),
        .bus_mrdy(bus_mrdy), .bus_rdata(bus_rdata), .bus_srdy(bus_srdy),
        .key_valid(key_valid), .key_char(key_char),
        .disp_done(disp_done), .disp_char(disp_char),
        .disp_load(disp_load), .irq(irq)
    );

    // Behavioural reference state
    logic       m_kw, m_dr, m_ken, m_den, m_srdy, m_load;
    logic [7:0] m_key, m_disp, m_rdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        logic hit, acc;
        int   off;
        logic [7:0] rm;
        if (!rst_n) begin
            m_kw = 0; m_dr = 1; m_ken = 0; m_den = 0;
            m_srdy = 0; m_load = 0; m_key = 0; m_disp = 0; m_rdata = 0;
        end else begin
            hit = (bus_addr[31:2] == BASE[31:2]);
            off = int'(bus_addr[1:0]);
            acc = bus_mrdy && hit && !m_srdy;
            case (off)
                0: rm = m_key;
                1: rm = m_disp;
                2: rm = {m_dr && m_den, m_kw && m_ken, 4'b0000, m_dr, m_kw};
                default: rm = {5'b00000, m_ken, m_den, 1'b0};
            endcase
            if (acc && bus_rnw && off == 0) m_kw = 0;
            if (key_valid) begin m_kw = 1; m_key = key_char; end
            if (disp_done) m_dr = 1;
            m_load = 0;
            if (acc && !bus_rnw && off == 1) begin
                m_dr = 0; m_disp = bus_wdata; m_load = 1;
            end
            if (acc && !bus_rnw && off == 3) begin
                m_ken = bus_wdata[2]; m_den = bus_wdata[1];
            end
            if (acc && bus_rnw) m_rdata = rm;
            m_srdy = acc;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !summary_done) begin
            check("R2 bus_srdy", bus_srdy, m_srdy);
            check("R7 irq", irq, (m_kw && m_ken) || (m_dr && m_den));
            check("R5 disp_load", disp_load, m_load);
            check("R5 disp_char", disp_char, m_disp);
            if (m_srdy) check("R8 bus_rdata", bus_rdata, m_rdata);
        end
    end

    // One handshake with optional device strobes in the access cycle
    task automatic xfer(input logic [31:0] a, input logic rnw, input logic [7:0] w,
                        input logic k, input logic [7:0] kc, input logic d,
                        output logic [7:0] r, output logic ld);
        bit got = 0;
        @(negedge clk);
        bus_addr = a; bus_rnw = rnw; bus_wdata = w; bus_mrdy = 1;
        key_valid = k; key_char = kc; disp_done = d;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            key_valid = 0; disp_done = 0;
            if (bus_srdy) begin got = 1; break; end
        end
        r = bus_rdata; ld = disp_load;
        bus_mrdy = 0;
        if (!got) check("R2 no answer", 0, 1);
    endtask

    task automatic rd(input int off, output logic [7:0] r);
        logic ld;
        xfer(BASE + off, 1, 8'h00, 0, 8'h00, 0, r, ld);
    endtask

    task automatic wr(input int off, input logic [7:0] w);
        logic [7:0] r; logic ld;
        xfer(BASE + off, 0, w, 0, 8'h00, 0, r, ld);
    endtask

    task automatic idle(input int n, input logic k, input logic [7:0] kc, input logic d);
        @(negedge clk);
        key_valid = k; key_char = kc; disp_done = d;
        @(negedge clk);
        key_valid = 0; disp_done = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!summary_done) begin
            summary_done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        logic ld;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        check("R9 srdy after reset", bus_srdy, 0);
        check("R9 irq after reset", irq, 0);
        rd(2, r); check("R9 status after reset", r, 8'h02);
        rd(3, r); check("R9 control after reset", r, 8'h00);

        // R3, R4: key delivery and read clear
        idle(1, 1, 8'h41, 0);
        rd(2, r); check("R3 status with key", r, 8'h03);
        rd(0, r); check("R4 key code", r, 8'h41);
        rd(2, r); check("R4 flag cleared", r, 8'h02);

        // R3: overwrite while waiting
        idle(1, 1, 8'h11, 0);
        idle(1, 1, 8'h22, 0);
        rd(2, r); check("R3 flag kept on overwrite", r, 8'h03);
        rd(0, r); check("R3 overwritten code", r, 8'h22);

        // R6, R7: enables and requests
        wr(3, 8'hFF);
        rd(3, r); check("R6 control unused bits zero", r, 8'h06);
        rd(2, r); check("R7 display request", r, 8'h82);
        check("R7 irq from display", irq, 1);
        wr(3, 8'h04);
        rd(2, r); check("R7 display request gated", r, 8'h02);
        check("R7 irq gated off", irq, 0);
        idle(1, 1, 8'h33, 0);
        rd(2, r); check("R7 keyboard request", r, 8'h43);
        check("R7 irq from keyboard", irq, 1);

        // R5, R8: display write
        xfer(BASE + 1, 0, 8'h5A, 0, 8'h00, 0, r, ld);
        check("R5 load strobe", ld, 1);
        check("R5 display char", disp_char, 8'h5A);
        rd(2, r); check("R5 ready cleared", r, 8'h41);
        rd(1, r); check("R8 display readback", r, 8'h5A);
        idle(1, 0, 8'h00, 1);
        rd(2, r); check("R5 ready after done", r, 8'h43);

        // R8: ignored writes
        wr(2, 8'h00);
        wr(0, 8'h00);
        rd(2, r); check("R8 status write ignored", r, 8'h43);
        rd(0, r); check("R8 key write ignored", r, 8'h33);
        rd(2, r); check("R4 flag cleared again", r, 8'h02);

        // R4: key strobe in the read cycle
        idle(1, 1, 8'h44, 0);
        xfer(BASE + 0, 1, 8'h00, 1, 8'h55, 0, r, ld);
        check("R4 collision returns old code", r, 8'h44);
        rd(2, r); check("R4 collision keeps flag", r, 8'h43);
        rd(0, r); check("R4 collision new code", r, 8'h55);

        // R5: done strobe in the write cycle
        xfer(BASE + 1, 0, 8'h66, 0, 8'h00, 1, r, ld);
        rd(2, r); check("R5 write beats done", r, 8'h00);
        idle(1, 0, 8'h00, 1);
        rd(2, r); check("R5 ready restored", r, 8'h02);

        // R1: addresses outside the window
        @(negedge clk);
        bus_addr = BASE + 4; bus_rnw = 0; bus_wdata = 8'h00; bus_mrdy = 1;
        repeat (5) begin
            @(negedge clk);
            check("R1 no answer above window", bus_srdy, 0);
        end
        bus_addr = BASE ^ 32'h0000_0103;
        repeat (3) begin
            @(negedge clk);
            check("R1 no answer other base", bus_srdy, 0);
        end
        bus_mrdy = 0;
        rd(3, r); check("R1 control unchanged", r, 8'h04);

        // R2: master holds request past the answer
        @(negedge clk);
        bus_addr = BASE + 3; bus_rnw = 1; bus_mrdy = 1;
        @(negedge clk);
        check("R2 answer pulse", bus_srdy, 1);
        @(negedge clk);
        check("R2 no repeat while answered", bus_srdy, 0);
        bus_mrdy = 0;
        @(negedge clk);

        // Mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 4));
            if (op == 4) begin
                idle(int'($urandom_range(0, 2)), $urandom_range(0, 1) == 1,
                     8'($urandom), $urandom_range(0, 1) == 1);
            end else begin
                xfer(BASE + op, $urandom_range(0, 1) == 1, 8'($urandom),
                     $urandom_range(0, 3) == 0, 8'($urandom),
                     $urandom_range(0, 3) == 0, r, ld);
            end
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule